// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core with Post-Increment Load

This block is a 32-bit load/store processor core that completes each instruction in one clock. In a single cycle it fetches a word from a private instruction array, decodes it, reads up to two registers, computes in the ALU, reads or writes a private data array, writes back and selects the next program counter. The instruction set covers register-to-register arithmetic and logic, a logical left shift by an immediate amount, load of an upper-half constant, word load and store, branch on equality, jump through a register, and a load that also advances its index register in the same cycle.

The two memories are arrays held inside the core. A testbench or a surrounding harness fills the instruction array while reset is held. The data array is reached only by the core's own loads and stores. A debug read port returns any register, and the current program counter is driven on an output, so that results can be observed without stopping the core. The post-increment load writes two registers in one cycle, so the register file has a second write port.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC becomes 0 and every register becomes 0 at that edge.
- R2: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0] and imm [15:0]. The word at instruction index PC/4 executes each cycle. Unless a branch is taken or a jump is made, the PC advances by 4.
- R3: Opcode 0x00 computes on rs and rt and writes rd. The funct code selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (writes 1 or 0).
- R4: Opcode 0x00 with funct 0x00 writes rd with rt shifted left by shamt, filling with zeros.
- R5: Opcode 0x0F writes rt with imm in bits 31:16 and zeros in bits 15:0.
- R6: Opcode 0x23 writes rt with the data word at index rs + sign-extended imm. Opcode 0x2B stores rt at that index. The index is the low log2(DMEM_WORDS) bits of the sum.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended imm << 2). Otherwise the next PC is PC + 4.
- R8: Opcode 0x00 with funct 0x08 loads the PC from rs and writes no register, whatever the rd field holds.
- R9: Opcode 0x30 writes rs with the data word at index imm + rt. In the same cycle it writes rt with rt + 1.
- R10: When opcode 0x30 names one register as both rs and rt, that register receives the loaded word.
- R11: Register 0 always reads as 0. Writes to it are ignored on both write ports.
- R12: `dbg_reg_data` returns the register selected by `dbg_reg_sel` without a clock delay. `pc_out` shows the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_reg_sel | input | 5 | Register number for the debug read |
| dbg_reg_data | output | 32 | Contents of the selected register |
| pc_out | output | 32 | Current program counter (byte address) |

## Verification
The bench builds the core with a 16-word instruction array and an 8-word data array. With these sizes every unused instruction slot can be filled with a self-loop, and each program can run to a fixed halt point before it is examined. The small data array also keeps a negative load/store offset inside a checkable range. Within that setting the bench sweeps all pairs from a set of six upper-half constants, chosen to include zero, one, the largest positive value, the sign bit and all ones. For each pair it checks every ALU operation and a shift amount that varies with the pair. Short directed programs then cover forward and backward branches, a jump whose rd field is nonzero, and the post-increment load with shared, zero and distinct register operands.

// File: rtl/sc_pkg.sv
// Shared encodings and types for the single-cycle core.
// Assumes a fixed 32-bit instruction word with 5-bit register fields.
package sc_pkg;

    localparam int INSTR_W  = 32;
    localparam int REG_AW   = 5;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_LUI   = 6'h0F;
    localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;
    localparam logic [OPC_W-1:0] OP_LDINC = 6'h30;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_JR  = 6'h08;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam logic [1:0] ALUOP_MEM   = 2'b00;
    localparam logic [1:0] ALUOP_BEQ   = 2'b01;
    localparam logic [1:0] ALUOP_FUNCT = 2'b10;
    localparam logic [1:0] ALUOP_LUI   = 2'b11;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_LUI
    } alu_fn_e;

    typedef enum logic [1:0] {
        DST_RT, DST_RD, DST_RS
    } dst_sel_e;

    typedef struct packed {
        dst_sel_e   reg_dst;
        logic       alu_src;
        logic       mem_to_reg;
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       branch;
        logic [1:0] alu_op;
        logic       jump_reg;
        logic       inc_write;
        logic       base_rt;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Main decoder and ALU control. Turns opcode and funct into datapath controls.
// Assumes unknown opcodes and unknown funct codes behave as no-operations.
module sc_decode
    import sc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [5:0]       funct,
    output ctrl_t            ctrl,
    output alu_fn_e          alu_fn
);

    // Main decoder: one control set per opcode.
    always_comb begin
        ctrl = '0;
        ctrl.reg_dst = DST_RT;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.reg_dst = DST_RD;
                ctrl.alu_op  = ALUOP_FUNCT;
                case (funct)
                    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT, FN_SLL:
                        ctrl.reg_write = 1'b1;
                    FN_JR:
                        ctrl.jump_reg = 1'b1;
                    default: ;
                endcase
            end
            OP_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.alu_op     = ALUOP_MEM;
            end
            OP_SW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
                ctrl.alu_op    = ALUOP_MEM;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALUOP_BEQ;
            end
            OP_LUI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = ALUOP_LUI;
            end
            OP_LDINC: begin
                ctrl.reg_dst    = DST_RS;
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.inc_write  = 1'b1;
                ctrl.base_rt    = 1'b1;
                ctrl.alu_op     = ALUOP_MEM;
            end
            default: ;
        endcase
    end

    // ALU control: ALU operation from the 2-bit class and the funct field.
    always_comb begin
        alu_fn = ALU_ADD;
        case (ctrl.alu_op)
            ALUOP_MEM: alu_fn = ALU_ADD;
            ALUOP_BEQ: alu_fn = ALU_SUB;
            ALUOP_LUI: alu_fn = ALU_LUI;
            default: begin
                case (funct)
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    FN_SLL:  alu_fn = ALU_SLL;
                    default: alu_fn = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Combinational ALU with a zero flag for the equality branch.
// Assumes XLEN is even and at least 2*SHW; the shift operates on operand b.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SHW-1:0]  shamt,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] result,
    output logic            zero
);

    localparam int HALF = XLEN / 2;

    // Operation select.
    always_comb begin
        case (fn)
            ALU_SUB: result = a - b;
            ALU_AND: result = a & b;
            ALU_OR:  result = a | b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL: result = b << shamt;
            ALU_LUI: result = {b[HALF-1:0], {HALF{1'b0}}};
            default: result = a + b;
        endcase
    end

    // Zero flag for the branch compare.
    assign zero = (result == '0);

endmodule

// File: rtl/sc_regfile.sv
// Register file: two read ports, a debug read port and two write ports.
// Register 0 is hard-wired to zero. Port A wins when both ports name one register.
module sc_regfile
    import sc_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NREGS = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ra_addr,
    output logic [XLEN-1:0]   ra_data,
    input  logic [REG_AW-1:0] rb_addr,
    output logic [XLEN-1:0]   rb_data,
    input  logic [REG_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data,
    input  logic              wa_en,
    input  logic [REG_AW-1:0] wa_addr,
    input  logic [XLEN-1:0]   wa_data,
    input  logic              wb_en,
    input  logic [REG_AW-1:0] wb_addr,
    input  logic [XLEN-1:0]   wb_data
);

    logic [XLEN-1:0] regs [NREGS];

    // Register 0 is a constant.
    assign regs[0] = '0;

    // One storage process per writable register.
    for (genvar i = 1; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wa_en && (wa_addr == REG_AW'(i)))
                regs[i] <= wa_data;
            else if (wb_en && (wb_addr == REG_AW'(i)))
                regs[i] <= wb_data;
        end
    end

    // Asynchronous reads.
    assign ra_data  = regs[ra_addr];
    assign rb_data  = regs[rb_addr];
    assign dbg_data = regs[dbg_addr];

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, instruction and data arrays, datapath wiring.
// Assumes 32-bit instructions, power-of-two array sizes, word-indexed data
// accesses, and an instruction array filled while rst_n is low.
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_data,
    output logic [XLEN-1:0]   pc_out
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam int SHW = $clog2(XLEN);

    logic [INSTR_W-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0]    dmem [DMEM_WORDS];

    logic [XLEN-1:0]    pc_q, pc_next, pc_plus4, br_target;
    logic [INSTR_W-1:0] instr;
    logic [OPC_W-1:0]   f_op;
    logic [REG_AW-1:0]  f_rs, f_rt, f_rd;
    logic [SHW-1:0]     f_shamt;
    logic [5:0]         f_funct;
    logic [IMM_W-1:0]   f_imm;
    logic [XLEN-1:0]    imm_ext;

    ctrl_t              ctrl;
    alu_fn_e            alu_fn;
    logic [XLEN-1:0]    rs_val, rt_val, alu_a, alu_b, alu_res, load_word, wa_data;
    logic               alu_zero, take_branch;
    logic [REG_AW-1:0]  wa_addr;
    logic [DAW-1:0]     d_idx;
    logic               unused_bits;

    // Instruction array starts as no-operations until loaded.
    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    // Fetch and field split.
    assign instr   = imem[pc_q[IAW+1:2]];
    assign f_op    = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_shamt = instr[6+SHW-1:6];
    assign f_funct = instr[5:0];
    assign f_imm   = instr[15:0];
    assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_funct),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    sc_regfile #(.XLEN(XLEN)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_addr  (f_rs),
        .ra_data  (rs_val),
        .rb_addr  (f_rt),
        .rb_data  (rt_val),
        .dbg_addr (dbg_reg_sel),
        .dbg_data (dbg_reg_data),
        .wa_en    (ctrl.reg_write),
        .wa_addr  (wa_addr),
        .wa_data  (wa_data),
        .wb_en    (ctrl.inc_write),
        .wb_addr  (f_rt),
        .wb_data  (rt_val + XLEN'(1))
    );

    // Operand selection: the post-increment load indexes from rt.
    assign alu_a = ctrl.base_rt ? rt_val : rs_val;
    assign alu_b = ctrl.alu_src ? imm_ext : rt_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a      (alu_a),
        .b      (alu_b),
        .shamt  (f_shamt),
        .fn     (alu_fn),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Data array access, word-indexed by the low bits of the ALU sum.
    assign d_idx     = alu_res[DAW-1:0];
    assign load_word = dmem[d_idx];

    // Data array store.
    always_ff @(posedge clk) begin
        if (ctrl.mem_write) dmem[d_idx] <= rt_val;
    end

    // Write-back destination and data for port A.
    always_comb begin
        case (ctrl.reg_dst)
            DST_RD:  wa_addr = f_rd;
            DST_RS:  wa_addr = f_rs;
            default: wa_addr = f_rt;
        endcase
    end
    assign wa_data = ctrl.mem_to_reg ? load_word : alu_res;

    // Next-PC selection.
    assign pc_plus4    = pc_q + XLEN'(4);
    assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign take_branch = ctrl.branch && alu_zero;
    assign pc_next     = ctrl.jump_reg ? rs_val : (take_branch ? br_target : pc_plus4);

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_out = pc_q;

    assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IAW+2], alu_res[XLEN-1:DAW],
                           instr[10:6+SHW], ctrl.mem_read};

endmodule

// File: rtl/sc_core_chk.sv
// Property checker for sc_core, attached to every instance by bind.
// Assumes the signal names of sc_core's datapath.
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic            jr_en,
    input logic            br_en,
    input logic            alu_zero,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] imm_ext,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            wa_en,
    input logic            wb_en
);

    // R1
    reset_pc_chk: assert property (@(posedge clk) !rst_n |=> pc == '0);

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!jr_en && !(br_en && alu_zero)) |=> pc == $past(pc) + XLEN'(4));

    // R7
    br_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && alu_zero) |=> pc == $past(pc) + XLEN'(4) + ($past(imm_ext) << 2));

    // R8
    jr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jr_en |=> pc == $past(rs_val));

    // R8
    jr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jr_en |-> (!wa_en && !wb_en));

    // R6
    ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, br_en, jr_en}));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_q),
    .jr_en    (ctrl.jump_reg),
    .br_en    (ctrl.branch),
    .alu_zero (alu_zero),
    .rs_val   (rs_val),
    .imm_ext  (imm_ext),
    .mem_rd   (ctrl.mem_read),
    .mem_wr   (ctrl.mem_write),
    .wa_en    (ctrl.reg_write),
    .wb_en    (ctrl.inc_write)
);

// File: tb/sim_sc_core.sv
// Self-checking bench: assembles short programs, runs each to a self-loop,
// then reads results through the debug port.
module sim_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int IMEM_W = 16;
    localparam int DMEM_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data, pc_val;

    int checks = 0;
    int errors = 0;

    logic [31:0] prog [IMEM_W];
    int          plen;

    sc_core #(.XLEN(32), .IMEM_WORDS(IMEM_W), .DMEM_WORDS(DMEM_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_reg_sel  (dbg_sel),
        .dbg_reg_data (dbg_data),
        .pc_out       (pc_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                          input int sh, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
        dbg_sel = r[4:0];
        #1;
        check(req, $sformatf("r%0d", r), dbg_data, exp);
    endtask

    // Hold reset, load the program padded with self-loops, release, run.
    task automatic load_and_run(input int ncyc);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < IMEM_W; i++)
            u0.imem[i] = (i < plen) ? prog[i] : HALT;
        rst_n = 1'b1;
        repeat (ncyc) @(posedge clk);
        @(negedge clk);
    endtask

    logic [15:0] vals [6];

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;

        // Sweep: R3 ALU ops, R4 shift, R5 upper constant, R2 sequencing.
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                logic [31:0] ea, eb;
                int sh;
                ea = {vals[i], 16'h0};
                eb = {vals[j], 16'h0};
                sh = (i * 7 + j * 3) % 32;
                plen = 0;
                emit(itype(6'h0F, 0, 1, vals[i]));
                emit(itype(6'h0F, 0, 2, vals[j]));
                emit(rtype(1, 2, 3, 0, 6'h20));
                emit(rtype(1, 2, 4, 0, 6'h22));
                emit(rtype(1, 2, 5, 0, 6'h24));
                emit(rtype(1, 2, 6, 0, 6'h25));
                emit(rtype(1, 2, 7, 0, 6'h2A));
                emit(rtype(0, 1, 8, sh, 6'h00));
                load_and_run(12);
                chk_reg("R5", 1, ea);
                chk_reg("R3", 3, ea + eb);
                chk_reg("R3", 4, ea - eb);
                chk_reg("R3", 5, ea & eb);
                chk_reg("R3", 6, ea | eb);
                chk_reg("R3", 7, ($signed(ea) < $signed(eb)) ? 32'd1 : 32'd0);
                chk_reg("R4", 8, ea << sh);
                check("R2", "pc at halt", pc_val, 32'd32);
                if (i == 0 && j == 1) begin
                    // R1: synchronous reset clears PC and registers.
                    rst_n = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                    check("R1", "pc in reset", pc_val, 32'd0);
                    chk_reg("R1", 2, 32'd0);
                    chk_reg("R1", 3, 32'd0);
                    chk_reg("R1", 8, 32'd0);
                end
            end
        end

        // Memory program: R6, R9, R10, R11.
        plen = 0;
        emit(itype(6'h0F, 0, 1, 16'hABCD));
        emit(itype(6'h2B, 0, 1, 16'd5));
        emit(itype(6'h23, 0, 3, 16'd5));
        emit(itype(6'h0F, 0, 4, 16'h1234));
        emit(itype(6'h2B, 0, 4, 16'd6));
        emit(itype(6'h30, 5, 6, 16'd5));
        emit(itype(6'h30, 7, 6, 16'd5));
        emit(itype(6'h30, 6, 6, 16'd4));
        emit(itype(6'h30, 0, 8, 16'd5));
        emit(itype(6'h30, 9, 0, 16'd6));
        emit(rtype(1, 1, 0, 0, 6'h20));
        emit(itype(6'h2B, 8, 1, 16'hFFFF));
        emit(itype(6'h23, 0, 10, 16'd0));
        load_and_run(18);
        chk_reg("R6", 3, 32'hABCD0000);
        chk_reg("R9", 5, 32'hABCD0000);
        chk_reg("R9", 7, 32'h12340000);
        chk_reg("R10", 6, 32'h12340000);
        chk_reg("R9", 8, 32'd1);
        chk_reg("R9", 9, 32'h12340000);
        chk_reg("R11", 0, 32'd0);
        chk_reg("R6", 10, 32'hABCD0000);

        // Branch program: R7 taken, not taken, forward skip, backward loop.
        plen = 0;
        emit(itype(6'h0F, 0, 1, 16'h0001));
        emit(itype(6'h0F, 0, 2, 16'h0001));
        emit(itype(6'h04, 1, 2, 16'd1));
        emit(itype(6'h0F, 0, 3, 16'h7777));
        emit(itype(6'h0F, 0, 4, 16'h5555));
        emit(itype(6'h04, 1, 0, 16'd1));
        emit(itype(6'h0F, 0, 5, 16'h6666));
        emit(itype(6'h04, 0, 0, 16'd2));
        emit(itype(6'h0F, 0, 6, 16'h1111));
        emit(itype(6'h0F, 0, 6, 16'h2222));
        load_and_run(16);
        chk_reg("R7", 3, 32'd0);
        chk_reg("R7", 4, 32'h55550000);
        chk_reg("R7", 5, 32'h66660000);
        chk_reg("R7", 6, 32'd0);
        check("R7", "pc at backward loop", pc_val, 32'd40);

        // Jump program: R8 target and no write to rd; R12 debug and pc.
        plen = 0;
        emit(itype(6'h0F, 0, 1, 16'h0001));
        emit(rtype(0, 1, 2, 0, 6'h2A));
        emit(rtype(0, 2, 3, 5, 6'h00));
        emit(rtype(3, 0, 5, 0, 6'h08));
        for (int k = 4; k < 8; k++) emit(itype(6'h0F, 0, 4, 16'h7777));
        emit(itype(6'h0F, 0, 6, 16'h2222));
        load_and_run(14);
        chk_reg("R4", 3, 32'd32);
        check("R8", "pc after jump", pc_val, 32'd36);
        chk_reg("R8", 4, 32'd0);
        chk_reg("R8", 5, 32'd0);
        chk_reg("R12", 6, 32'h22220000);
        chk_reg("R12", 2, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule